// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address and count engine of one DMA channel. When software raises the enable input, the channel loads a source start address, a destination start address and a transfer count. It also captures the transfer size (byte or halfword), an increment-or-fixed choice for each side, and the ring mode select. For each transfer it then produces the current source and destination addresses and the byte lanes to use on a 16-bit data bus. A requester asks for each transfer on `xferReq`. The sequencer grants the transfer on `xferAck` in the same cycle and advances its state at the next clock edge.

There are two modes. In normal mode the count falls by one per transfer, and the channel stops and raises `done` once the count reaches zero. In ring mode every incrementing address steps only inside a 32-transfer window. After 32 transfers it is back at its start. The count is frozen, and the channel runs until software drops the enable. A ring window must start on a window boundary. A ring start whose incrementing side is misaligned raises `cfgError` in place of running.

Top module: `dma_addr_seq`

## Requirements
- R1: In normal mode each acknowledged transfer lowers `countNow` by exactly one, for byte and for halfword size alike.
- R2: At byte size each side's lanes follow that side's own address bit 0: 0 gives `2'b01` (bus bits 7:0) and 1 gives `2'b10` (bus bits 15:8). Source and destination are independent, so odd-to-even and even-to-odd moves work.
- R3: At halfword size both sides always report lanes `2'b11`, whatever the value of address bit 0.
- R4: In ring mode at byte size an incrementing address keeps bits 31:5 and steps bits 4:0 by one, wrapping from 5'b11111 to 5'b00000, so it returns to its start after 32 transfers.
- R5: In ring mode at halfword size an incrementing address keeps bits 31:6 and steps bits 5:0 by two, wrapping from 6'b111110 to 6'b000000, so it returns to its start after 32 transfers.
- R6: An address on a fixed side never changes. In normal mode an incrementing address steps by 1 (byte) or 2 (halfword) with the carry across all 32 bits.
- R7: In ring mode the loaded count is ignored, even when it is zero. `countNow` holds its value, `done` stays low and transfers keep being granted while enable stays high.
- R8: In normal mode `done` rises in the cycle after the transfer that brings the count to zero, and later requests are not acknowledged. A start with count 0 raises `done` at once and grants no transfer.
- R9: A ring-mode start where an incrementing side's start address has non-zero bits 4:0 (byte) or 5:0 (halfword) sets `cfgError`, and no transfer is granted. A fixed side is not checked.
- R10: `xferAck` equals `xferReq` while the channel is running and enabled. Addresses and count change at the clock edge that ends the acknowledged cycle. Clearing enable blocks `xferAck` in that same cycle and aborts the channel, and a later enable reloads the start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcStart | input | 32 | Source start address |
| dstStart | input | 32 | Destination start address |
| countInit | input | 16 | Transfer count to load |
| sizeWide | input | 1 | 1 = halfword transfers, 0 = byte transfers |
| srcInc | input | 1 | 1 = source address increments, 0 = fixed |
| dstInc | input | 1 | 1 = destination address increments, 0 = fixed |
| ringMode | input | 1 | 1 = ring mode, 0 = normal mode |
| enable | input | 1 | Channel enable; a rise from idle starts the channel, a fall aborts it |
| xferReq | input | 1 | Request for one transfer |
| xferAck | output | 1 | Transfer granted this cycle |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| srcLanes | output | 2 | Source byte lanes on the 16-bit bus |
| dstLanes | output | 2 | Destination byte lanes on the 16-bit bus |
| countNow | output | 16 | Remaining transfer count |
| active | output | 1 | Channel is running |
| done | output | 1 | Normal-mode count exhausted |
| cfgError | output | 1 | Misaligned ring start rejected |

## Verification
Several properties are checked on every cycle. A fixed side never moves. A ring step never touches the bits above the window. The count drops by exactly one on a normal step and holds on a ring step. No grant is given while disabled, done or in error. Other behaviour can only be shown by the directed scenarios: the exact address sequences, the wrap back to start after 32 ring transfers, the carry across the upper address bits in normal mode, the lane patterns for odd and even addresses, the zero-count start, the rejection of a misaligned ring start, and the reload after an abort.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } seq_strobe_t;

  typedef struct packed {
    logic countIsOne;
    logic countInitZero;
    logic misalign;
    logic ringLatched;
    logic ringRaw;
  } seq_status_t;

endpackage

// File: rtl/dma_seq_addr_unit.sv
module dma_seq_addr_unit #(
  parameter int ADDR_W    = 32,
  parameter int RING_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              incRaw,
  input  logic              wideRaw,
  input  logic              ringRaw,
  input  logic              incQ,
  input  logic              wideQ,
  input  logic              ringQ,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        lanes,
  output logic              misalign
);

  localparam logic [ADDR_W-1:0] MASK_BYTE = (ADDR_W'(1) << RING_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MASK_HALF = (ADDR_W'(1) << (RING_BITS + 1)) - ADDR_W'(1);

  logic [ADDR_W-1:0] stepSize;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] ringMask;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] rawMask;

  always_comb begin
    stepSize = wideQ ? ADDR_W'(2) : ADDR_W'(1);
    sum      = addr + stepSize;
    ringMask = wideQ ? MASK_HALF : MASK_BYTE;
    if (!incQ)
      nextAddr = addr;
    else if (ringQ)
      nextAddr = (addr & ~ringMask) | (sum & ringMask);
    else
      nextAddr = sum;
  end

  always_comb begin
    rawMask  = wideRaw ? MASK_HALF : MASK_BYTE;
    misalign = ringRaw && incRaw && ((startAddr & rawMask) != '0);
  end

  always_comb begin
    if (wideQ)
      lanes = 2'b11;
    else
      lanes = addr[0] ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      addr <= '0;
    else if (load)
      addr <= startAddr;
    else if (step)
      addr <= nextAddr;
  end

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && !incQ) |=> (addr == $past(addr)))
    else $error("fixed side moved"); // R6

  AST_RING_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && incQ && ringQ) |=> ((addr & ~MASK_HALF) == ($past(addr) & ~MASK_HALF)))
    else $error("ring step left window"); // R5

  AST_RING_UPPER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && incQ && ringQ && !wideQ) |=> ((addr & ~MASK_BYTE) == ($past(addr) & ~MASK_BYTE)))
    else $error("byte ring step left window"); // R4

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int RING_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [CNT_W-1:0]  countInit,
  input  logic              sizeWide,
  input  logic              srcInc,
  input  logic              dstInc,
  input  logic              ringMode,
  output seq_status_t       status,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        srcLanes,
  output logic [1:0]        dstLanes,
  output logic [CNT_W-1:0]  countNow
);

  localparam int SIDES = 2;

  logic wideQ, ringQ;
  logic [SIDES-1:0] incQ;
  logic [SIDES-1:0] incRaw;
  logic [SIDES-1:0] sideMisalign;
  logic [ADDR_W-1:0] startArr [SIDES];
  logic [ADDR_W-1:0] addrArr  [SIDES];
  logic [1:0]        lanesArr [SIDES];

  assign incRaw      = {dstInc, srcInc};
  assign startArr[0] = srcStart;
  assign startArr[1] = dstStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideQ <= 1'b0;
      ringQ <= 1'b0;
      incQ  <= '0;
    end else if (strobe.load) begin
      wideQ <= sizeWide;
      ringQ <= ringMode;
      incQ  <= incRaw;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_seq_addr_unit #(
      .ADDR_W   (ADDR_W),
      .RING_BITS(RING_BITS)
    ) u_addr (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.load),
      .step     (strobe.step),
      .startAddr(startArr[s]),
      .incRaw   (incRaw[s]),
      .wideRaw  (sizeWide),
      .ringRaw  (ringMode),
      .incQ     (incQ[s]),
      .wideQ    (wideQ),
      .ringQ    (ringQ),
      .addr     (addrArr[s]),
      .lanes    (lanesArr[s]),
      .misalign (sideMisalign[s])
    );
  end

  assign srcAddr  = addrArr[0];
  assign dstAddr  = addrArr[1];
  assign srcLanes = lanesArr[0];
  assign dstLanes = lanesArr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      countNow <= '0;
    else if (strobe.load)
      countNow <= countInit;
    else if (strobe.step && !ringQ)
      countNow <= countNow - CNT_W'(1);
  end

  always_comb begin
    status.countIsOne    = (countNow == CNT_W'(1));
    status.countInitZero = (countInit == '0);
    status.misalign      = |sideMisalign;
    status.ringLatched   = ringQ;
    status.ringRaw       = ringMode;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !ringQ) |=> (countNow == $past(countNow) - CNT_W'(1)))
    else $error("count did not drop by one"); // R1

  AST_RING_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && ringQ) |=> $stable(countNow))
    else $error("count moved in ring mode"); // R7

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        xferReq,
  input  seq_status_t status,
  output seq_strobe_t strobe,
  output logic        xferAck,
  output logic        active,
  output logic        done,
  output logic        cfgError
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_e;

  seq_state_e state, stateNext;

  always_comb begin
    xferAck     = (state == ST_RUN) && enable && xferReq;
    strobe.step = xferAck;
    strobe.load = (state == ST_IDLE) && enable && !status.misalign;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          if (status.misalign)
            stateNext = ST_ERR;
          else if (!status.ringRaw && status.countInitZero)
            stateNext = ST_HALT;
          else
            stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!enable)
          stateNext = ST_IDLE;
        else if (xferAck && !status.ringLatched && status.countIsOne)
          stateNext = ST_HALT;
      end
      ST_HALT, ST_ERR: begin
        if (!enable)
          stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= ST_IDLE;
    else
      state <= stateNext;
  end

  assign active   = (state == ST_RUN);
  assign done     = (state == ST_HALT);
  assign cfgError = (state == ST_ERR);

  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> (enable && !done && !cfgError))
    else $error("grant while disabled or stopped"); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (xferAck && !status.ringLatched && status.countIsOne) |=> (done || !enable))
    else $error("last transfer did not finish"); // R8

  AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !xferAck)
    else $error("grant in error state"); // R9

  AST_RING_NEVER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (active && status.ringLatched && enable) |=> !done)
    else $error("ring channel finished"); // R7

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int RING_LEN  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [CNT_W-1:0]  countInit,
  input  logic              sizeWide,
  input  logic              srcInc,
  input  logic              dstInc,
  input  logic              ringMode,
  input  logic              enable,
  input  logic              xferReq,
  output logic              xferAck,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        srcLanes,
  output logic [1:0]        dstLanes,
  output logic [CNT_W-1:0]  countNow,
  output logic              active,
  output logic              done,
  output logic              cfgError
);

  localparam int RING_BITS = $clog2(RING_LEN);

  seq_strobe_t strobe;
  seq_status_t status;

  dma_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .xferReq (xferReq),
    .status  (status),
    .strobe  (strobe),
    .xferAck (xferAck),
    .active  (active),
    .done    (done),
    .cfgError(cfgError)
  );

  dma_seq_dpath #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .RING_BITS(RING_BITS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcStart (srcStart),
    .dstStart (dstStart),
    .countInit(countInit),
    .sizeWide (sizeWide),
    .srcInc   (srcInc),
    .dstInc   (dstInc),
    .ringMode (ringMode),
    .status   (status),
    .srcAddr  (srcAddr),
    .dstAddr  (dstAddr),
    .srcLanes (srcLanes),
    .dstLanes (dstLanes),
    .countNow (countNow)
  );

endmodule

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;

  localparam time CLK_HALF = 2.5ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcStart = '0, dstStart = '0;
  logic [15:0] countInit = '0;
  logic        sizeWide = 1'b0, srcInc = 1'b0, dstInc = 1'b0, ringMode = 1'b0;
  logic        enable = 1'b0, xferReq = 1'b0;
  logic        xferAck;
  logic [31:0] srcAddr, dstAddr;
  logic [1:0]  srcLanes, dstLanes;
  logic [15:0] countNow;
  logic        active, done, cfgError;

  int checks = 0;
  int errors = 0;
  logic ackSeen;

  always #CLK_HALF clk = ~clk;

  dma_addr_seq uut (
    .clk(clk), .rstN(rstN), .srcStart(srcStart), .dstStart(dstStart),
    .countInit(countInit), .sizeWide(sizeWide), .srcInc(srcInc), .dstInc(dstInc),
    .ringMode(ringMode), .enable(enable), .xferReq(xferReq), .xferAck(xferAck),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcLanes(srcLanes), .dstLanes(dstLanes),
    .countNow(countNow), .active(active), .done(done), .cfgError(cfgError)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic startCh(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                         input logic w, input logic si, input logic di, input logic r);
    @(negedge clk);
    srcStart = s; dstStart = d; countInit = c;
    sizeWide = w; srcInc = si; dstInc = di; ringMode = r;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic stopCh();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic xfer();
    @(negedge clk);
    xferReq = 1'b1;
    #1 ackSeen = xferAck;
    @(negedge clk);
    xferReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R10 reset ack", 32'(xferAck), 0);
    chk("R8 reset done", 32'(done), 0);
    chk("R9 reset error", 32'(cfgError), 0);
    chk("R6 reset src", srcAddr, 0);
    chk("R1 reset count", 32'(countNow), 0);
  endtask

  task automatic testNormalByte();
    startCh(32'h1000_0003, 32'h2000_0010, 16'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 load src", srcAddr, 32'h1000_0003);
    chk("R1 load count", 32'(countNow), 3);
    chk("R2 odd src lane", 32'(srcLanes), 32'h2);
    chk("R2 even dst lane", 32'(dstLanes), 32'h1);
    @(negedge clk);
    xferReq = 1'b1;
    #1;
    chk("R10 same-cycle ack", 32'(xferAck), 1);
    chk("R10 addr before edge", srcAddr, 32'h1000_0003);
    @(negedge clk);
    xferReq = 1'b0;
    chk("R6 byte step", srcAddr, 32'h1000_0004);
    chk("R2 even src lane", 32'(srcLanes), 32'h1);
    chk("R1 count after one", 32'(countNow), 2);
    for (int i = 0; i < 2; i++) xfer();
    chk("R6 fixed dst", dstAddr, 32'h2000_0010);
    chk("R6 src after three", srcAddr, 32'h1000_0006);
    chk("R1 count empty", 32'(countNow), 0);
    chk("R8 done raised", 32'(done), 1);
    xfer();
    chk("R8 no ack after done", 32'(ackSeen), 0);
    chk("R8 src held after done", srcAddr, 32'h1000_0006);
    stopCh();
  endtask

  task automatic testNormalHalf();
    startCh(32'h0000_FFFE, 32'h1234_5679, 16'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R3 src lanes", 32'(srcLanes), 32'h3);
    chk("R3 odd dst lanes", 32'(dstLanes), 32'h3);
    xfer();
    chk("R6 carry into upper bits", srcAddr, 32'h0001_0000);
    chk("R6 halfword dst step", dstAddr, 32'h1234_567B);
    chk("R1 halfword count", 32'(countNow), 1);
    xfer();
    chk("R8 done halfword", 32'(done), 1);
    stopCh();
  endtask

  task automatic testZeroCount();
    startCh(32'h0000_0100, 32'h0000_0200, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8 zero count done", 32'(done), 1);
    xfer();
    chk("R8 zero count no ack", 32'(ackSeen), 0);
    chk("R8 zero count src held", srcAddr, 32'h0000_0100);
    stopCh();
  endtask

  task automatic testRingByte();
    startCh(32'hABCD_EF20, 32'h5555_0007, 16'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 aligned ring ok", 32'(cfgError), 0);
    for (int i = 1; i <= 40; i++) begin
      xfer();
      chk("R7 ring ack", 32'(ackSeen), 1);
      chk("R4 ring byte addr", srcAddr, 32'hABCD_EF20 | 32'(i % 32));
    end
    chk("R6 fixed dst in ring", dstAddr, 32'h5555_0007);
    chk("R7 count ignored", 32'(countNow), 0);
    chk("R7 not done", 32'(done), 0);
    @(negedge clk);
    enable = 1'b0; xferReq = 1'b1;
    #1 chk("R10 disable blocks ack", 32'(xferAck), 0);
    @(negedge clk);
    xferReq = 1'b0;
    chk("R10 idle after disable", 32'(active), 0);
    chk("R10 no step while disabled", srcAddr, 32'hABCD_EF28);
  endtask

  task automatic testRingHalf();
    startCh(32'h0000_1040, 32'h8000_0000, 16'd9, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 1; i <= 31; i++) xfer();
    chk("R5 before wrap", srcAddr, 32'h0000_107E);
    xfer();
    chk("R5 src wrap to start", srcAddr, 32'h0000_1040);
    chk("R5 dst wrap to start", dstAddr, 32'h8000_0000);
    xfer();
    chk("R5 step by two", srcAddr, 32'h0000_1042);
    chk("R7 count held", 32'(countNow), 9);
    stopCh();
  endtask

  task automatic testMisalign();
    startCh(32'h0000_0021, 32'h0000_0040, 16'd4, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 byte misaligned error", 32'(cfgError), 1);
    xfer();
    chk("R9 no ack on error", 32'(ackSeen), 0);
    stopCh();
    startCh(32'h0000_0020, 32'h0000_0020, 16'd4, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 halfword misaligned error", 32'(cfgError), 1);
    stopCh();
    startCh(32'h0000_0040, 32'h0000_0003, 16'd4, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 fixed side unchecked", 32'(cfgError), 0);
    chk("R9 fixed side runs", 32'(active), 1);
    stopCh();
  endtask

  task automatic testAbortReload();
    startCh(32'h0000_0500, 32'h0000_0600, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    xfer(); xfer();
    chk("R1 count mid run", 32'(countNow), 3);
    stopCh();
    chk("R8 abort not done", 32'(done), 0);
    startCh(32'h0000_0500, 32'h0000_0600, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 reload src", srcAddr, 32'h0000_0500);
    chk("R10 reload count", 32'(countNow), 5);
    stopCh();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormalByte();
    testNormalHalf();
    testZeroCount();
    testRingByte();
    testRingHalf();
    testMisalign();
    testAbortReload();
    report();
  end

endmodule